// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

The router collects the interrupt sources that belong to each processor core and turns them into one pending word and one IRQ line per core. Every core has four generic timer lines, four mailbox summary lines, and a performance-monitor line. There is also one fast external interrupt, which is shared and is delivered to a single core chosen by a parameter. Timer lines pass only when the matching bit of that core's timer control word is set. The performance-monitor line of core n passes only when bit n of a routing mask is set. The mailbox summaries and the external line arrive already qualified and pass through unchanged.

Software reaches the block over a simple register bus. The bus has an address, a write strobe, 32-bit write data and combinational read data. Each core's timer control word is written whole, so a change to it is a read-modify-write. The routing mask has two addresses: writing 1s to the set address enables routing for those cores, and writing 1s to the clear address disables it. Bits written as 0 leave the mask unchanged, so no read-modify-write is needed. Each core's pending word can be read at its own address. The pending word shows the live, gated source levels and does not latch them. A core's IRQ output is high whenever any bit of its pending word is high.

Top module: `core_irq_router`

## Requirements
- R1: After reset every timer control word and the routing mask are zero, so every core's IRQ stays low while timer or performance-monitor sources are high.
- R2: A write to address TMR_BASE+4*c stores write data bits [3:0] into core c's timer control word. A read of that address returns those four bits, with bits [31:4] zero. The words of other cores are left unchanged.
- R3: Pending bit k (k=0..3) of core c equals timer source c*4+k AND control bit k. The order is secure physical, non-secure physical, hypervisor, virtual.
- R4: A write to PMU_SET ORs write data bits [NCORE-1:0] into the routing mask. Bits written as zero keep their value. A read of PMU_SET or PMU_CLR returns the mask, zero-extended.
- R5: A write to PMU_CLR clears the routing-mask bits where the write data holds a 1. All other bits keep their value.
- R6: Pending bit 9 of core c equals pmu_src[c] AND routing-mask bit c.
- R7: Pending bits 4..7 of core c equal mbox_src[c*4+3 : c*4], with no gating.
- R8: Pending bit 8 equals ext_fast_src on core EXT_CORE and is zero on every other core.
- R9: The pending word read at PEND_BASE+4*c follows the source levels in the same cycle. A bit falls as soon as its source falls. Bits [31:10] read zero.
- R10: core_irq[c] is high exactly when core c's pending word is non-zero.
- R11: A read of an unmapped address returns zero. A write to an unmapped address or to a pending-word address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_src | input | 4*NCORE | Timer interrupt levels, four per core |
| mbox_src | input | 4*NCORE | Mailbox summary levels, four per core |
| ext_fast_src | input | 1 | Shared fast external interrupt level |
| pmu_src | input | NCORE | Performance-monitor interrupt level per core |
| core_irq | output | NCORE | IRQ output per core |

## Verification
Several properties are checked on every cycle by assertions. A set or clear write to the routing mask has a visible effect on the bits it targets. Unmapped writes leave the mask stable. No timer pending bit is high while its enable is low. An IRQ is never raised without some source line of that core being high. The bench scenarios are needed for the rest: the exact bit position of each source in the pending word, that writes to one core do not leak into a neighbour's word, that read data for unmapped and upper bits is zero, and that the pending word drops at once when a source falls.

// File: rtl/core_irq_router.sv
module core_irq_router #(
  parameter int unsigned NCORE     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TMR_BASE  = 'h00,
  parameter int unsigned PMU_SET   = 'h30,
  parameter int unsigned PMU_CLR   = 'h34,
  parameter int unsigned PEND_BASE = 'h40,
  parameter int unsigned EXT_CORE  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [4*NCORE-1:0]   tmr_src,
  input  logic [4*NCORE-1:0]   mbox_src,
  input  logic                 ext_fast_src,
  input  logic [NCORE-1:0]     pmu_src,
  output logic [NCORE-1:0]     core_irq
);
  localparam int unsigned PW = 10;

  logic [NCORE-1:0] pmu_route;
  logic [PW-1:0]    pend   [NCORE];
  logic [3:0]       tmr_rd [NCORE];
  logic             addr_hit;

  wire set_wr = bus_we && (bus_addr == ADDR_W'(PMU_SET));
  wire clr_wr = bus_we && (bus_addr == ADDR_W'(PMU_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pmu_route <= '0;
    else if (set_wr) pmu_route <= pmu_route | bus_wdata[NCORE-1:0];
    else if (clr_wr) pmu_route <= pmu_route & ~bus_wdata[NCORE-1:0];
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [3:0] en_q;
    wire wr_hit = bus_we && (bus_addr == ADDR_W'(TMR_BASE + 4*c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (wr_hit) en_q <= bus_wdata[3:0];
    end

    wire ext_bit = (c == EXT_CORE) ? ext_fast_src : 1'b0;

    assign tmr_rd[c]   = en_q;
    assign pend[c]     = {pmu_src[c] & pmu_route[c], ext_bit,
                          mbox_src[c*4 +: 4], tmr_src[c*4 +: 4] & en_q};
    assign core_irq[c] = |pend[c];

    assert_tmr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c][3:0] & ~en_q) == 4'd0);

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      core_irq[c] |-> (|{tmr_src[c*4 +: 4], mbox_src[c*4 +: 4], ext_fast_src, pmu_src[c]}));

    assert_tmr_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> en_q == 4'd0);
  end

  always_comb begin
    bus_rdata = '0;
    addr_hit  = 1'b0;
    if (bus_addr == ADDR_W'(PMU_SET) || bus_addr == ADDR_W'(PMU_CLR)) begin
      bus_rdata = 32'(pmu_route);
      addr_hit  = 1'b1;
    end
    for (int c = 0; c < NCORE; c++) begin
      if (bus_addr == ADDR_W'(TMR_BASE + 4*c)) begin
        bus_rdata = {28'd0, tmr_rd[c]};
        addr_hit  = 1'b1;
      end
      if (bus_addr == ADDR_W'(PEND_BASE + 4*c)) begin
        bus_rdata = 32'(pend[c]);
        addr_hit  = 1'b1;
      end
    end
  end

  assert_pmu_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((pmu_route & $past(bus_wdata[NCORE-1:0])) == $past(bus_wdata[NCORE-1:0])));

  assert_pmu_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pmu_route & $past(bus_wdata[NCORE-1:0])) == '0));

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !addr_hit) |=> $stable(pmu_route));

  assert_route_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pmu_route == '0);
endmodule

// File: tb/core_irq_router_tb_top.sv
module core_irq_router_tb_top;
  localparam int N = 4;
  localparam logic [7:0] TMR = 8'h00, PSET = 8'h30, PCLR = 8'h34, PEND = 8'h40;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4*N-1:0] tmr_src = '0, mbox_src = '0;
  logic ext_fast_src = 0;
  logic [N-1:0] pmu_src = '0, core_irq;

  int tests = 0, fails = 0;
  logic [3:0] m_en [N];
  logic [N-1:0] m_route;

  always #5 clk = ~clk;

  core_irq_router dut_i (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .tmr_src, .mbox_src, .ext_fast_src, .pmu_src, .core_irq);

  function automatic logic [31:0] exp_pend(int c);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) v[k] = tmr_src[c*4+k] & m_en[c][k];
    for (int k = 0; k < 4; k++) v[4+k] = mbox_src[c*4+k];
    v[8] = (c == 0) ? ext_fast_src : 1'b0;
    v[9] = pmu_src[c] & m_route[c];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    if (a == PSET) m_route |= d[N-1:0];
    else if (a == PCLR) m_route &= ~d[N-1:0];
    else for (int c = 0; c < N; c++) if (a == TMR + 8'(4*c)) m_en[c] = d[3:0];
  endtask

  task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < N; c++) begin
      rd(PEND + 8'(4*c), tag, exp_pend(c));
      check({tag, " R10 irq"}, 32'(core_irq[c]), 32'(exp_pend(c) != 0));
    end
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < N; c++) m_en[c] = '0;
    m_route = '0;
    tmr_src = '1; pmu_src = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: sources high but all gated off
    check("R1 irq", 32'(core_irq), 32'd0);
    rd(PSET, "R1 route", 32'd0);
    for (int c = 0; c < N; c++) rd(TMR + 8'(4*c), "R1 tmr", 32'd0);

    // R2: per-core timer word, upper bits dropped, no leak
    wr(TMR + 8'd4, 32'hFFFF_FFF5);
    rd(TMR + 8'd4, "R2 core1", 32'h5);
    rd(TMR, "R2 core0 untouched", 32'h0);
    rd(TMR + 8'd8, "R2 core2 untouched", 32'h0);

    // R3: each timer bit position gated individually
    tmr_src = '0;
    for (int k = 0; k < 4; k++) begin
      wr(TMR + 8'd8, 32'(1 << k));
      tmr_src = 16'(1 << (8 + k));
      #1 rd(PEND + 8'd8, "R3 timer bit", 32'(1 << k));
      tmr_src = 16'(1 << (8 + ((k + 1) % 4)));
      #1 rd(PEND + 8'd8, "R3 other bit masked", 32'd0);
    end
    tmr_src = '0;

    // R4 / R5 / R6: routing mask set and clear
    pmu_src = '1;
    wr(PSET, 32'h5);
    rd(PCLR, "R4 set", 32'h5);
    wr(PSET, 32'h2);
    rd(PSET, "R4 zero bits keep", 32'h7);
    wr(PCLR, 32'h4);
    rd(PSET, "R5 clear", 32'h3);
    rd(PEND + 8'd4, "R6 core1 pmu", 32'h200);
    rd(PEND + 8'd12, "R6 core3 pmu off", 32'h0);
    check("R6 irq", 32'(core_irq), 32'h3);
    wr(PCLR, 32'hF);
    pmu_src = '0;

    // R7 / R8: mailbox and external
    mbox_src = 16'hA000;
    ext_fast_src = 1;
    #1 rd(PEND + 8'd12, "R7 mbox core3", 32'h0A0);
    rd(PEND, "R8 ext core0", 32'h100);
    rd(PEND + 8'd4, "R8 ext not core1", 32'h0);

    // R9: level, not latched
    mbox_src = '0; ext_fast_src = 0;
    #1 rd(PEND + 8'd12, "R9 drop", 32'h0);
    check("R9 irq", 32'(core_irq), 32'h0);

    // R11: unmapped and pending writes ignored
    wr(8'h10, 32'hF); wr(8'hF0, 32'hF); wr(PEND, 32'hFFFF_FFFF); wr(8'h38, 32'hF);
    rd(8'h10, "R11 unmapped read", 32'h0);
    rd(8'hF0, "R11 unmapped read", 32'h0);
    rd(PSET, "R11 route unchanged", 32'h0);
    rd(TMR, "R11 tmr unchanged", 32'h0);

    // random phase
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      int s;
      s = int'($urandom_range(0, 5));
      case (s)
        0, 1: a = TMR + 8'(4 * $urandom_range(0, N - 1));
        2: a = PSET;
        3: a = PCLR;
        4: a = PEND + 8'(4 * $urandom_range(0, N - 1));
        default: a = 8'($urandom_range(8'h80, 8'hFF));
      endcase
      wr(a, $urandom());
      tmr_src = 16'($urandom()); mbox_src = 16'($urandom());
      pmu_src = 4'($urandom()); ext_fast_src = 1'($urandom());
      #1 check_all("R3 R6 R7 R8 R9 random");
      rd(PSET, "R4 R5 random route", 32'(m_route));
      for (int c = 0; c < N; c++) rd(TMR + 8'(4*c), "R2 R11 random tmr", 32'(m_en[c]));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule